// File: doc/BRIEF.md
# Bridge Bring-Up Gate

This block controls access to a bus bridge during bring-up. It sits between the CPU register port, the bridge's register file and the bridge's external bus logic. Bring-up has two stages. A master enable bit opens CPU access to the bridge's registers. A separate init-complete bit then opens traffic on the external bus. The block owns both bits and decodes every CPU register cycle. From its state and from a host/normal mode strap, it produces per-cycle permits:

- register-file write enable,
- read-data masking,
- outbound request forwarding or rejection,
- arbiter enable,
- fixed grant to the bridge itself,
- accept or retry for inbound requests.

A finite-state machine holds the state, with four states:

- `ST_SAMPLE`: the single cycle after reset release, in which the strap is captured.
- `ST_OFF`: the enable bit is 0.
- `ST_CONFIG`: the enable bit is 1 and the init-complete bit is 0.
- `ST_RUN`: both bits are 1.

The transitions are:

- `T_STRAP`: SAMPLE→OFF, always.
- `T_ENABLE`: OFF→CONFIG, on an enable write of 1.
- `T_DISABLE`: CONFIG→OFF, on an enable write of 0.
- `T_INIT_DONE`: CONFIG→RUN, on a control write of 1.
- `T_REINIT`: RUN→CONFIG, on a control write of 0.
- `T_SHUTDOWN`: RUN→OFF, on an enable write of 0. This also drops the init-complete bit.

Software sets the enable bit first. While the block is in CONFIG, software loads the bridge's command, status, subsystem-ID and local-window registers. It then sets the init-complete bit.

Top module: `brg_gate`

## Requirements
- R1: After reset, both bits read 0. The enable register is at `ENA_ADDR`, bit 0. The control register is at `CTRL_ADDR`, bit 0. An outbound request is rejected.
- R2: While enable is 0, a CPU write to any address other than `ENA_ADDR` gives `rf_we`=0. A read from any such address returns 0.
- R3: A read of `ENA_ADDR` returns the enable bit in bit 0 in every state. A write of `cpu_wbit` sets or clears the enable bit. Clearing it from RUN also clears init-complete.
- R4: In host mode with init-complete 0, `gnt_self`=1 and `arb_en`=0.
- R5: With init-complete 0, every inbound request (`ib_req`) gets `ib_retry`=1 and `ib_accept`=0, in the same cycle.
- R6: With init-complete 1, host mode gives `arb_en`=1 and `gnt_self`=0. An inbound request gets `ib_accept`=1 and `ib_retry`=0 in either mode.
- R7: An outbound request gets, in the same cycle, exactly one of two answers. It gets `ob_fwd`=1 when init-complete is 1, and `ob_err`=1 otherwise.
- R8: With enable 1 and init-complete 0, writes to register-file addresses give `rf_we`=1, and reads return `rf_rdata`.
- R9: A control write of 1 while enable is 0 is ignored. After enable is later set, init-complete still reads 0.
- R10: The mode strap (1 = host) is captured in the first cycle after reset release. Later changes to it have no effect until the next reset.
- R11: A control write of 0 in RUN returns the block to CONFIG. Outbound requests are then rejected again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_strap | input | 1 | Mode strap, 1 = host |
| cpu_req | input | 1 | CPU register cycle valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | CPU register word address |
| cpu_wbit | input | 1 | Bit 0 of the CPU write data |
| rf_rdata | input | DW | Read data from the register file |
| cpu_rdata | output | DW | Read data returned to the CPU |
| rf_we | output | 1 | Register-file write permit |
| ob_req | input | 1 | Outbound bus request from the bridge |
| ob_fwd | output | 1 | Outbound request forwarded |
| ob_err | output | 1 | Outbound request rejected |
| ib_req | input | 1 | Inbound access from an external device |
| ib_accept | output | 1 | Inbound access accepted |
| ib_retry | output | 1 | Inbound access answered with retry |
| arb_en | output | 1 | Enable for the external arbiter |
| gnt_self | output | 1 | Fixed grant to the bridge itself |

## Verification
The permits are decoded combinationally from the registered state. A wrong state therefore shows at the ports in the very cycle it exists. It appears as a rejected or forwarded outbound request, a retry where an accept was due, or a wrong grant or arbiter enable. A lost or spurious transition can also be seen on the next read of the enable or control register. A mode captured wrongly or recaptured later makes grant and arbiter-enable disagree with the strap that was present at reset release.

// File: rtl/brg_gate_pkg.sv
package brg_gate_pkg;

    typedef enum logic [1:0] {
        ST_SAMPLE = 2'd0,
        ST_OFF    = 2'd1,
        ST_CONFIG = 2'd2,
        ST_RUN    = 2'd3
    } gate_state_e;

    // decoded, already-validated control-register writes
    typedef struct packed {
        logic ena_wr;
        logic ena_val;
        logic ctl_wr;
        logic ctl_val;
    } gate_cmd_t;

endpackage

// File: rtl/brg_gate_fsm.sv
module brg_gate_fsm
    import brg_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_strap,
    input  gate_cmd_t   cmd,
    output gate_state_e st,
    output logic        host_q,
    output logic        en_bit,
    output logic        init_bit
);

    gate_state_e st_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_SAMPLE;
        else        st <= st_nxt;
    end

    // strap capture: only in the sample state
    always_ff @(posedge clk) begin
        if (!rst_n)                host_q <= 1'b0;
        else if (st == ST_SAMPLE)  host_q <= host_strap;
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_SAMPLE: st_nxt = ST_OFF;                                   // T_STRAP
            ST_OFF: begin
                if (cmd.ena_wr && cmd.ena_val) st_nxt = ST_CONFIG;        // T_ENABLE
            end
            ST_CONFIG: begin
                if (cmd.ena_wr && !cmd.ena_val)     st_nxt = ST_OFF;      // T_DISABLE
                else if (cmd.ctl_wr && cmd.ctl_val) st_nxt = ST_RUN;      // T_INIT_DONE
            end
            ST_RUN: begin
                if (cmd.ena_wr && !cmd.ena_val)      st_nxt = ST_OFF;     // T_SHUTDOWN
                else if (cmd.ctl_wr && !cmd.ctl_val) st_nxt = ST_CONFIG;  // T_REINIT
            end
            default: st_nxt = ST_SAMPLE;
        endcase
    end

    // bit views
    always_comb begin
        en_bit   = 1'b0;
        init_bit = 1'b0;
        unique case (st)
            ST_SAMPLE: begin en_bit = 1'b0; init_bit = 1'b0; end
            ST_OFF:    begin en_bit = 1'b0; init_bit = 1'b0; end
            ST_CONFIG: begin en_bit = 1'b1; init_bit = 1'b0; end
            ST_RUN:    begin en_bit = 1'b1; init_bit = 1'b1; end
            default:   begin en_bit = 1'b0; init_bit = 1'b0; end
        endcase
    end

endmodule

// File: rtl/brg_gate_regport.sv
module brg_gate_regport
    import brg_gate_pkg::*;
#(
    parameter int          AW        = 8,
    parameter int          DW        = 32,
    parameter logic [AW-1:0] ENA_ADDR  = '0,
    parameter logic [AW-1:0] CTRL_ADDR = AW'(1)
) (
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_wbit,
    input  logic [DW-1:0] rf_rdata,
    input  logic          en_bit,
    input  logic          init_bit,
    output logic [DW-1:0] cpu_rdata,
    output logic          rf_we,
    output gate_cmd_t     cmd
);

    localparam int PADW = DW - 1;

    logic hit_ena, hit_ctl, hit_rf, rd, wr;

    always_comb begin
        hit_ena = (cpu_addr == ENA_ADDR);
        hit_ctl = (cpu_addr == CTRL_ADDR);
        hit_rf  = !hit_ena && !hit_ctl;
        rd      = cpu_req && !cpu_we;
        wr      = cpu_req &&  cpu_we;
    end

    // writes: enable register always valid, everything else needs enable
    always_comb begin
        cmd.ena_wr  = wr && hit_ena;
        cmd.ena_val = cpu_wbit;
        cmd.ctl_wr  = wr && hit_ctl && en_bit;
        cmd.ctl_val = cpu_wbit;
        rf_we       = wr && hit_rf && en_bit;
    end

    // reads: zero unless enabled, except the enable register itself
    always_comb begin
        cpu_rdata = '0;
        if (rd) begin
            if (hit_ena)
                cpu_rdata = {{PADW{1'b0}}, en_bit};
            else if (hit_ctl)
                cpu_rdata = en_bit ? {{PADW{1'b0}}, init_bit} : '0;
            else
                cpu_rdata = en_bit ? rf_rdata : '0;
        end
    end

endmodule

// File: rtl/brg_gate_busperm.sv
module brg_gate_busperm
    import brg_gate_pkg::*;
(
    input  gate_state_e st,
    input  logic        host_q,
    input  logic        ob_req,
    input  logic        ib_req,
    output logic        ob_fwd,
    output logic        ob_err,
    output logic        ib_accept,
    output logic        ib_retry,
    output logic        arb_en,
    output logic        gnt_self
);

    always_comb begin
        ob_fwd    = 1'b0;
        ob_err    = 1'b0;
        ib_accept = 1'b0;
        ib_retry  = 1'b0;
        arb_en    = 1'b0;
        gnt_self  = 1'b0;
        unique case (st)
            ST_SAMPLE: begin
                // mode not yet known: hold everything off
                ob_err   = ob_req;
                ib_retry = ib_req;
            end
            ST_OFF, ST_CONFIG: begin
                ob_err   = ob_req;
                ib_retry = ib_req;
                gnt_self = host_q;
            end
            ST_RUN: begin
                ob_fwd    = ob_req;
                ib_accept = ib_req;
                arb_en    = host_q;
            end
            default: begin
                ob_err   = ob_req;
                ib_retry = ib_req;
            end
        endcase
    end

endmodule

// File: rtl/brg_gate.sv
module brg_gate
    import brg_gate_pkg::*;
#(
    parameter int            AW        = 8,
    parameter int            DW        = 32,
    parameter logic [AW-1:0] ENA_ADDR  = '0,
    parameter logic [AW-1:0] CTRL_ADDR = AW'(1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_strap,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_wbit,
    input  logic [DW-1:0] rf_rdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          rf_we,
    input  logic          ob_req,
    output logic          ob_fwd,
    output logic          ob_err,
    input  logic          ib_req,
    output logic          ib_accept,
    output logic          ib_retry,
    output logic          arb_en,
    output logic          gnt_self
);

    gate_state_e st;
    gate_cmd_t   cmd;
    logic        host_q, en_bit, init_bit;

    brg_gate_regport #(
        .AW(AW), .DW(DW), .ENA_ADDR(ENA_ADDR), .CTRL_ADDR(CTRL_ADDR)
    ) u_regport (
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wbit  (cpu_wbit),
        .rf_rdata  (rf_rdata),
        .en_bit    (en_bit),
        .init_bit  (init_bit),
        .cpu_rdata (cpu_rdata),
        .rf_we     (rf_we),
        .cmd       (cmd)
    );

    brg_gate_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_strap (host_strap),
        .cmd        (cmd),
        .st         (st),
        .host_q     (host_q),
        .en_bit     (en_bit),
        .init_bit   (init_bit)
    );

    brg_gate_busperm u_busperm (
        .st        (st),
        .host_q    (host_q),
        .ob_req    (ob_req),
        .ib_req    (ib_req),
        .ob_fwd    (ob_fwd),
        .ob_err    (ob_err),
        .ib_accept (ib_accept),
        .ib_retry  (ib_retry),
        .arb_en    (arb_en),
        .gnt_self  (gnt_self)
    );

endmodule

// File: rtl/brg_gate_chk.sv
module brg_gate_chk
    import brg_gate_pkg::*;
#(
    parameter int            AW        = 8,
    parameter int            DW        = 32,
    parameter logic [AW-1:0] ENA_ADDR  = '0,
    parameter logic [AW-1:0] CTRL_ADDR = AW'(1)
) (
    input logic          clk,
    input logic          rst_n,
    input gate_state_e   st,
    input logic          host_q,
    input logic          cpu_req,
    input logic          cpu_we,
    input logic [AW-1:0] cpu_addr,
    input logic [DW-1:0] cpu_rdata,
    input logic          rf_we,
    input logic          ob_req,
    input logic          ob_fwd,
    input logic          ob_err,
    input logic          ib_req,
    input logic          ib_accept,
    input logic          ib_retry,
    input logic          arb_en,
    input logic          gnt_self
);

    logic on;
    assign on = (st == ST_CONFIG) || (st == ST_RUN);

    p_rf_we_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> on);

    p_off_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && cpu_addr != ENA_ADDR && !on) |-> cpu_rdata == '0);

    p_ena_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && cpu_addr == ENA_ADDR) |-> cpu_rdata[0] == on);

    p_host_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_OFF || st == ST_CONFIG) && host_q) |-> (gnt_self && !arb_en));

    p_pre_init_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_RUN && ib_req) |-> (ib_retry && !ib_accept));

    p_run_from_config_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && $past(st) != ST_RUN) |-> $past(st) == ST_CONFIG);

    p_ob_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_req && st != ST_RUN) |-> (ob_err && !ob_fwd));

    p_ob_answered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ob_req |-> (ob_fwd != ob_err));

    p_init_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!on && cpu_req && cpu_we && cpu_addr == CTRL_ADDR) |=> st != ST_RUN);

    p_strap_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_SAMPLE) |=> $stable(host_q));

endmodule

bind brg_gate brg_gate_chk #(
    .AW(AW), .DW(DW), .ENA_ADDR(ENA_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .host_q    (host_q),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_rdata (cpu_rdata),
    .rf_we     (rf_we),
    .ob_req    (ob_req),
    .ob_fwd    (ob_fwd),
    .ob_err    (ob_err),
    .ib_req    (ib_req),
    .ib_accept (ib_accept),
    .ib_retry  (ib_retry),
    .arb_en    (arb_en),
    .gnt_self  (gnt_self)
);

// File: tb/tb_brg_gate.sv
`timescale 1ns/1ps
module tb_brg_gate;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [AW-1:0] A_ENA = 8'h00;
    localparam logic [AW-1:0] A_CTL = 8'h01;
    localparam logic [AW-1:0] A_RF  = 8'h05;
    localparam logic [DW-1:0] RF_VAL = 32'hC0DE_0005;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_strap = 1'b1;
    logic          cpu_req = 1'b0, cpu_we = 1'b0, cpu_wbit = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] rf_rdata = RF_VAL;
    logic [DW-1:0] cpu_rdata;
    logic          rf_we, ob_req = 1'b0, ob_fwd, ob_err;
    logic          ib_req = 1'b0, ib_accept, ib_retry, arb_en, gnt_self;

    always #2.5 clk = ~clk;

    brg_gate #(.AW(AW), .DW(DW), .ENA_ADDR(A_ENA), .CTRL_ADDR(A_CTL)) dut (
        .clk(clk), .rst_n(rst_n), .host_strap(host_strap),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wbit(cpu_wbit), .rf_rdata(rf_rdata), .cpu_rdata(cpu_rdata),
        .rf_we(rf_we), .ob_req(ob_req), .ob_fwd(ob_fwd), .ob_err(ob_err),
        .ib_req(ib_req), .ib_accept(ib_accept), .ib_retry(ib_retry),
        .arb_en(arb_en), .gnt_self(gnt_self)
    );

    // sel: 0 rdata, 1 rf_we, 2 ob_fwd, 3 ob_err, 4 arb_en, 5 gnt_self, 6 ib_accept, 7 ib_retry
    typedef struct {
        int          sel;
        logic [31:0] val;
        string       rq;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    function automatic logic [31:0] observe(int sel);
        case (sel)
            0: return cpu_rdata;
            1: return {31'd0, rf_we};
            2: return {31'd0, ob_fwd};
            3: return {31'd0, ob_err};
            4: return {31'd0, arb_en};
            5: return {31'd0, gnt_self};
            6: return {31'd0, ib_accept};
            default: return {31'd0, ib_retry};
        endcase
    endfunction

    task automatic ex(int sel, logic [31:0] val, string rq);
        item_t it;
        it.sel = sel; it.val = val; it.rq = rq;
        q.push_back(it);
    endtask

    task automatic op(logic req, logic we, logic [AW-1:0] a, logic wb,
                      logic obr, logic ibr);
        @(negedge clk);
        cpu_req = req; cpu_we = we; cpu_addr = a; cpu_wbit = wb;
        ob_req = obr; ib_req = ibr;
    endtask

    task automatic idle();
        op(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_reset(logic strap);
        @(negedge clk);
        rst_n = 1'b0;
        host_strap = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // monitor: compares queued expectations 1 ns after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = observe(it.sel);
                checks++;
                if (act !== it.val) begin
                    errors++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.rq, it.sel, act, it.val);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // ---------------- host mode ----------------
        do_reset(1'b1);
        idle();                                   // SAMPLE -> OFF done
        op(1, 0, A_ENA, 0, 1, 0);
        ex(0, 32'd0, "R1 enable reads 0");
        ex(3, 1, "R1 ob rejected"); ex(2, 0, "R1 ob not fwd");
        ex(5, 1, "R4 gnt_self"); ex(4, 0, "R4 arb off");
        op(1, 0, A_CTL, 0, 0, 0);
        ex(0, 32'd0, "R1 ctrl reads 0");
        op(1, 1, A_RF, 1, 0, 0);
        ex(1, 0, "R2 rf write dropped");
        op(1, 0, A_RF, 0, 0, 0);
        ex(0, 32'd0, "R2 rf read zero");
        op(1, 1, A_CTL, 1, 0, 0);                 // R9: invalid init set
        ex(1, 0, "R9 ctrl write no rf_we");
        op(0, 0, '0, 0, 1, 1);
        ex(3, 1, "R9 still blocked"); ex(7, 1, "R5 retry pre-init host");
        host_strap = 1'b0;                        // R10: late strap change
        op(1, 1, A_ENA, 1, 0, 0);                 // T_ENABLE
        op(1, 0, A_ENA, 0, 0, 0);
        ex(0, 32'd1, "R3 enable reads 1");
        op(1, 0, A_CTL, 0, 0, 0);
        ex(0, 32'd0, "R9 init still 0");
        op(1, 1, A_RF, 0, 0, 0);
        ex(1, 1, "R8 rf write allowed");
        op(1, 0, A_RF, 0, 1, 0);
        ex(0, RF_VAL, "R8 rf read passes");
        ex(3, 1, "R7 ob blocked in config"); ex(2, 0, "R7 ob not fwd config");
        ex(5, 1, "R10 still host grant"); ex(4, 0, "R4 arb off config");
        op(1, 1, A_CTL, 1, 0, 0);                 // T_INIT_DONE
        op(1, 0, A_CTL, 0, 1, 1);
        ex(0, 32'd1, "R6 init reads 1");
        ex(2, 1, "R7 ob forwarded"); ex(3, 0, "R7 ob no err");
        ex(4, 1, "R10 arb on (host kept)"); ex(5, 0, "R6 gnt_self off");
        ex(6, 1, "R6 ib accepted"); ex(7, 0, "R6 ib no retry");
        op(1, 1, A_CTL, 0, 0, 0);                 // T_REINIT
        op(0, 0, '0, 0, 1, 0);
        ex(3, 1, "R11 ob blocked again"); ex(5, 1, "R11 grant back");
        op(1, 1, A_CTL, 1, 0, 0);                 // back to RUN
        op(1, 1, A_ENA, 0, 0, 0);                 // T_SHUTDOWN
        op(1, 0, A_ENA, 0, 0, 0);
        ex(0, 32'd0, "R3 enable cleared");
        op(1, 1, A_ENA, 1, 0, 0);                 // re-enable
        op(1, 0, A_CTL, 0, 1, 0);
        ex(0, 32'd0, "R3 init cleared by shutdown");
        ex(3, 1, "R3 ob blocked after shutdown");

        // ---------------- normal mode ----------------
        do_reset(1'b0);
        idle();
        op(0, 0, '0, 0, 0, 1);
        ex(7, 1, "R5 retry normal"); ex(6, 0, "R5 no accept");
        ex(5, 0, "R4 no grant normal"); ex(4, 0, "R4 arb off normal");
        host_strap = 1'b1;                        // R10 late change
        op(1, 1, A_ENA, 1, 0, 0);
        op(0, 0, '0, 0, 0, 1);
        ex(7, 1, "R5 retry config");
        op(1, 1, A_CTL, 1, 0, 0);
        op(0, 0, '0, 0, 1, 1);
        ex(6, 1, "R6 ib accept normal"); ex(7, 0, "R6 no retry normal");
        ex(4, 0, "R10 arb stays off normal"); ex(2, 1, "R7 fwd normal");
        idle();
        idle();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule